// File: doc/BRIEF.md
# Vectored Interrupt Controller with Polling Fallback

This block collects three peripheral completion events for a small 4-bit core: end of an analog-to-digital conversion, a timer underflow, and the end of a serial transfer. Each event sets its own request flag. The core writes a control register that holds one enable bit for each vector slot. It also writes a select bit and sets or clears a global interrupt enable. Whenever an enabled slot has a pending flag and the global enable is on, the block raises an interrupt request. The request carries a page number and an in-page vector address, and the core services it by pulsing an acknowledge.

The timer and serial events share one slot. That slot has one enable bit and one vector, and the select bit decides which of the two flags feeds it. The conversion slot has its own enable bit and its own vector, and it wins over the shared slot when both are pending.

If a slot's enable bit is clear, its flags cannot interrupt. The core can instead poll them with a skip-if-set operation. A poll that finds its flag set clears the flag and returns a one-cycle skip pulse.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A one-cycle pulse on `evt_adc`, `evt_tmr` or `evt_ser` sets the matching bit of `req_flags` (bit 0 conversion, bit 1 timer, bit 2 serial) at the next clock edge. The bit holds until an acknowledge or a poll clears it.
- R2: The conversion slot requests an interrupt only when control bit 2, the global enable and flag bit 0 are all 1. The global enable is set by `gie_set` and cleared by `gie_clr`; `gie_clr` wins when both are high.
- R3: Control bit 3 enables the shared slot. With the select bit at 0 the timer flag drives that slot, and with the select bit at 1 the serial flag drives it. The flag that is not selected never raises `irq_req`.
- R4: `irq_page` is 1 whenever a request is shown. `irq_vec` is 0xC for the conversion slot and 0xE for the shared slot.
- R5: When both slots are pending and enabled, the conversion slot is presented (vector 0xC).
- R6: `irq_ack` while `irq_req` is high clears the flag being serviced and the global enable at the same edge. Acknowledge clears the global enable even if `gie_set` is high in that cycle.
- R7: `poll_req` with `poll_src` 0 (conversion), 1 (timer) or 2 (serial) selects a flag. If that flag's slot enable bit is 0 and the flag is set, the flag is cleared and `skip` is high for exactly the next cycle. Otherwise the poll changes nothing and `skip` stays low. `poll_src` 3 never matches any flag.
- R8: An event that arrives in the same cycle as the acknowledge or poll that clears its flag leaves the flag set.
- R9: After reset, all flags, the control register, the select bit, the global enable and `skip` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_adc | input | 1 | Conversion-complete event pulse |
| evt_tmr | input | 1 | Timer underflow event pulse |
| evt_ser | input | 1 | Serial transfer-complete event pulse |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 4 | Control value (bit 2 conversion slot enable, bit 3 shared slot enable) |
| sel_wr | input | 1 | Write strobe for the shared-slot select bit |
| sel_wdata | input | 1 | Select value: 0 timer, 1 serial |
| gie_set | input | 1 | Set the global interrupt enable |
| gie_clr | input | 1 | Clear the global interrupt enable |
| irq_ack | input | 1 | Core accepts the presented interrupt |
| poll_req | input | 1 | Skip-if-set poll operation |
| poll_src | input | 2 | Polled flag: 0 conversion, 1 timer, 2 serial, 3 none |
| irq_req | output | 1 | Interrupt request to the core |
| irq_page | output | 3 | Page of the vector address |
| irq_vec | output | 4 | In-page vector address |
| skip | output | 1 | One-cycle skip result of a successful poll |
| req_flags | output | 3 | Request flags: bit 0 conversion, 1 timer, 2 serial |

## Verification
Flags, the control register, the select bit and the global enable are registered, so each reacts at the first edge after its stimulus. `irq_req`, `irq_page` and `irq_vec` are decoded from those registers without further delay, so they change in that same cycle. `skip` is registered and is high only in the cycle after the poll's edge. The bench applies inputs at the falling edge and advances a behavioural model at each rising edge. It compares every output at the next falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        SRC_ADC  = 2'd0,
        SRC_TMR  = 2'd1,
        SRC_SER  = 2'd2,
        SRC_NONE = 2'd3
    } irq_src_e;
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    // a fresh event outranks a clear so no request is lost (R8)
    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/irq_slot_arbiter.sv
module irq_slot_arbiter
    import irq_pkg::*;
#(
    parameter int              CTL_W      = 4,
    parameter int              ADC_EN_BIT = 2,
    parameter int              SH_EN_BIT  = 3,
    parameter int              VEC_W      = 4,
    parameter logic [VEC_W-1:0] ADC_VEC   = 4'hC,
    parameter logic [VEC_W-1:0] SH_VEC    = 4'hE
) (
    input  logic [NUM_SRC-1:0] flags_i,
    input  logic [CTL_W-1:0]   ctl_i,
    input  logic               sel_i,
    input  logic               gie_i,
    output logic               req_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               adc_win_o
);
    logic slot_flag, adc_pend, sh_pend;

    always_comb begin
        slot_flag = sel_i ? flags_i[SRC_SER] : flags_i[SRC_TMR];
        adc_pend  = gie_i && ctl_i[ADC_EN_BIT] && flags_i[SRC_ADC];
        sh_pend   = gie_i && ctl_i[SH_EN_BIT] && slot_flag;
        req_o     = adc_pend || sh_pend;
        adc_win_o = adc_pend;
        vec_o     = adc_pend ? ADC_VEC : SH_VEC;
    end
endmodule

// File: rtl/irq_poll_unit.sv
module irq_poll_unit
    import irq_pkg::*;
#(
    parameter int CTL_W      = 4,
    parameter int ADC_EN_BIT = 2,
    parameter int SH_EN_BIT  = 3
) (
    input  logic               poll_req_i,
    input  logic [1:0]         poll_src_i,
    input  logic [NUM_SRC-1:0] flags_i,
    input  logic [CTL_W-1:0]   ctl_i,
    output logic [NUM_SRC-1:0] hit_o
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
        logic en;
        if (g == int'(SRC_ADC)) begin : g_adc
            assign en = ctl_i[ADC_EN_BIT];
        end else begin : g_sh
            assign en = ctl_i[SH_EN_BIT];
        end
        assign hit_o[g] = poll_req_i && (poll_src_i == 2'(g)) && !en && flags_i[g];
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int               CTL_W      = 4,
    parameter int               ADC_EN_BIT = 2,
    parameter int               SH_EN_BIT  = 3,
    parameter int               VEC_W      = 4,
    parameter int               PAGE_W     = 3,
    parameter logic [PAGE_W-1:0] VEC_PAGE  = 3'd1,
    parameter logic [VEC_W-1:0] ADC_VEC    = 4'hC,
    parameter logic [VEC_W-1:0] SH_VEC     = 4'hE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_adc,
    input  logic               evt_tmr,
    input  logic               evt_ser,
    input  logic               ctl_wr,
    input  logic [CTL_W-1:0]   ctl_wdata,
    input  logic               sel_wr,
    input  logic               sel_wdata,
    input  logic               gie_set,
    input  logic               gie_clr,
    input  logic               irq_ack,
    input  logic               poll_req,
    input  logic [1:0]         poll_src,
    output logic               irq_req,
    output logic [PAGE_W-1:0]  irq_page,
    output logic [VEC_W-1:0]   irq_vec,
    output logic               skip,
    output logic [NUM_SRC-1:0] req_flags
);
    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic             sel;
        logic             gie;
        logic             skip;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic [NUM_SRC-1:0] evt_vec, ack_clr, poll_hit, flags;
    logic               adc_win, ack_ok;

    assign evt_vec = {evt_ser, evt_tmr, evt_adc};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
        irq_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (evt_vec[g]),
            .clr_i  (ack_clr[g] | poll_hit[g]),
            .flag_o (flags[g])
        );
    end

    irq_slot_arbiter #(
        .CTL_W(CTL_W), .ADC_EN_BIT(ADC_EN_BIT), .SH_EN_BIT(SH_EN_BIT),
        .VEC_W(VEC_W), .ADC_VEC(ADC_VEC), .SH_VEC(SH_VEC)
    ) u_arb (
        .flags_i   (flags),
        .ctl_i     (st_q.ctl),
        .sel_i     (st_q.sel),
        .gie_i     (st_q.gie),
        .req_o     (irq_req),
        .vec_o     (irq_vec),
        .adc_win_o (adc_win)
    );

    irq_poll_unit #(
        .CTL_W(CTL_W), .ADC_EN_BIT(ADC_EN_BIT), .SH_EN_BIT(SH_EN_BIT)
    ) u_poll (
        .poll_req_i (poll_req),
        .poll_src_i (poll_src),
        .flags_i    (flags),
        .ctl_i      (st_q.ctl),
        .hit_o      (poll_hit)
    );

    assign ack_ok = irq_ack && irq_req;

    always_comb begin
        ack_clr          = '0;
        ack_clr[SRC_ADC] = ack_ok && adc_win;
        ack_clr[SRC_TMR] = ack_ok && !adc_win && !st_q.sel;
        ack_clr[SRC_SER] = ack_ok && !adc_win && st_q.sel;

        st_d = st_q;
        if (ctl_wr)  st_d.ctl = ctl_wdata;
        if (sel_wr)  st_d.sel = sel_wdata;
        if (gie_set) st_d.gie = 1'b1;
        if (gie_clr) st_d.gie = 1'b0;
        if (ack_ok)  st_d.gie = 1'b0;
        st_d.skip = |poll_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_page  = VEC_PAGE;
    assign skip      = st_q.skip;
    assign req_flags = flags;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
    parameter int CTL_W = 4,
    parameter int VEC_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       evt_vec,
    input logic [2:0]       req_flags,
    input logic [CTL_W-1:0] ctl,
    input logic             gie,
    input logic             irq_req,
    input logic             irq_ack,
    input logic [VEC_W-1:0] irq_vec,
    input logic             poll_req,
    input logic             skip
);
    // R1 / R8: an event always leaves its flag set after the edge
    a_r1_evt_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec != 3'b000) |=> ((req_flags & $past(evt_vec)) == $past(evt_vec)));

    a_r2_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gie);

    // R5: an enabled conversion request beats the shared slot
    a_r5_adc_first: assert property (@(posedge clk) disable iff (!rst_n)
        (gie && ctl[2] && req_flags[0]) |-> (irq_req && irq_vec == 4'hC));

    a_r6_ack_drops_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !gie);

    a_r7_skip_after_poll: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> $past(poll_req));

    a_r9_reset_clean: assert property (@(posedge clk)
        !rst_n |=> (req_flags == 3'b000 && !skip && !gie));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.CTL_W(CTL_W), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_vec   ({evt_ser, evt_tmr, evt_adc}),
    .req_flags (req_flags),
    .ctl       (st_q.ctl),
    .gie       (st_q.gie),
    .irq_req   (irq_req),
    .irq_ack   (irq_ack),
    .irq_vec   (irq_vec),
    .poll_req  (poll_req),
    .skip      (skip)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_adc = 0, evt_tmr = 0, evt_ser = 0;
    logic       ctl_wr = 0;
    logic [3:0] ctl_wdata = 0;
    logic       sel_wr = 0, sel_wdata = 0;
    logic       gie_set = 0, gie_clr = 0, irq_ack = 0, poll_req = 0;
    logic [1:0] poll_src = 0;
    logic       irq_req, skip;
    logic [2:0] irq_page;
    logic [3:0] irq_vec;
    logic [2:0] req_flags;

    int    n_tests = 0, n_fail = 0;
    string cur_req = "R9";
    bit    done = 0;

    // behavioural reference state
    bit m_fa, m_ft, m_fs, m_sel, m_gie, m_skip;
    bit [3:0] m_ctl;

    always #4 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .evt_adc(evt_adc), .evt_tmr(evt_tmr), .evt_ser(evt_ser),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .gie_set(gie_set), .gie_clr(gie_clr), .irq_ack(irq_ack),
        .poll_req(poll_req), .poll_src(poll_src),
        .irq_req(irq_req), .irq_page(irq_page), .irq_vec(irq_vec),
        .skip(skip), .req_flags(req_flags)
    );

    function automatic bit m_pa();
        return m_gie && m_ctl[2] && m_fa;
    endfunction
    function automatic bit m_ps();
        return m_gie && m_ctl[3] && (m_sel ? m_fs : m_ft);
    endfunction

    task automatic model_edge();
        bit pa = m_pa(), ps = m_ps();
        bit ack_ok = irq_ack && (pa || ps);
        bit ca = ack_ok && pa, ct = ack_ok && !pa && !m_sel, cs = ack_ok && !pa && m_sel;
        bit pa_hit = poll_req && poll_src == 0 && !m_ctl[2] && m_fa;
        bit pt_hit = poll_req && poll_src == 1 && !m_ctl[3] && m_ft;
        bit ps_hit = poll_req && poll_src == 2 && !m_ctl[3] && m_fs;
        m_fa = evt_adc || (m_fa && !(ca || pa_hit));
        m_ft = evt_tmr || (m_ft && !(ct || pt_hit));
        m_fs = evt_ser || (m_fs && !(cs || ps_hit));
        m_skip = pa_hit || pt_hit || ps_hit;
        if (gie_set) m_gie = 1;
        if (gie_clr) m_gie = 0;
        if (ack_ok)  m_gie = 0;
        if (ctl_wr)  m_ctl = ctl_wdata;
        if (sel_wr)  m_sel = sel_wdata;
    endtask

    task automatic compare();
        bit       e_req = m_pa() || m_ps();
        bit [3:0] e_vec = m_pa() ? 4'hC : 4'hE;
        bit [2:0] e_fl  = {m_fs, m_ft, m_fa};
        n_tests++;
        if (irq_req !== e_req || skip !== m_skip || req_flags !== e_fl ||
            (e_req && (irq_vec !== e_vec || irq_page !== 3'd1))) begin
            n_fail++;
            $display("FAIL %s: req=%b skip=%b flags=%b page=%0d vec=%h expected req=%b skip=%b flags=%b page=1 vec=%h",
                     cur_req, irq_req, skip, req_flags, irq_page, irq_vec,
                     e_req, m_skip, e_fl, e_vec);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        evt_adc = 0; evt_tmr = 0; evt_ser = 0; ctl_wr = 0; sel_wr = 0;
        gie_set = 0; gie_clr = 0; irq_ack = 0; poll_req = 0; poll_src = 0;
    endtask

    task automatic wr_ctl(input logic [3:0] v);
        ctl_wr = 1; ctl_wdata = v; step();
    endtask
    task automatic wr_sel(input logic v);
        sel_wr = 1; sel_wdata = v; step();
    endtask
    task automatic poll(input logic [1:0] s);
        poll_req = 1; poll_src = s; step(); step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare();                      // R9 during reset
        rst_n = 1;
        step();                         // R9 after release

        cur_req = "R1";
        evt_adc = 1; step();
        evt_tmr = 1; step();
        evt_ser = 1; step();
        step();

        cur_req = "R7";                 // enables 0: polling valid
        poll(2'd0);
        poll(2'd1);
        poll(2'd1);                     // flag now clear: no skip
        poll(2'd3);                     // code 3 matches nothing
        poll(2'd2);

        cur_req = "R2";
        evt_adc = 1; step();
        wr_ctl(4'h4);                   // enabled, gie still 0
        gie_set = 1; gie_clr = 1; step(); // clr wins
        gie_set = 1; step();            // request, vector 0xC

        cur_req = "R6";
        irq_ack = 1; gie_set = 1; step();
        step();

        cur_req = "R3";
        wr_sel(1'b0);
        wr_ctl(4'h8);
        gie_set = 1; step();
        evt_ser = 1; step();            // not selected: no request
        evt_tmr = 1; step();            // request, vector 0xE
        cur_req = "R6";
        irq_ack = 1; step();
        cur_req = "R3";
        wr_sel(1'b1);
        gie_set = 1; step();            // serial drives slot
        cur_req = "R4";
        irq_ack = 1; step();

        cur_req = "R5";
        wr_ctl(4'hC);
        evt_adc = 1; evt_tmr = 1; evt_ser = 1; step();
        gie_set = 1; step();
        irq_ack = 1; step();
        gie_set = 1; step();            // shared slot now shown
        irq_ack = 1; step();

        cur_req = "R7";                 // slot enabled: poll ignored
        poll(2'd0);
        poll(2'd1);

        cur_req = "R8";
        gie_set = 1; irq_ack = 1; evt_adc = 1; step(); // not pending yet
        step();
        irq_ack = 1; evt_adc = 1; step();              // ack + new event
        wr_ctl(4'h0);
        poll_req = 1; poll_src = 0; evt_adc = 1; step(); // poll + new event
        step();
        poll(2'd0);
        repeat (3) step();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule